// File: doc/BRIEF.md
# APB Transfer Observer

A passive monitor for one peripheral on an APB bus. Every bus signal is an input to the block, and the block drives nothing back onto the bus. It follows the phases of each transfer. When the handshake completes, it produces one record that holds the address, the data, the direction, the protection attributes and the error status. It also keeps two sticky flags. One marks an access phase that had no setup phase before it. The other marks a control or data signal that changed while it had to stay stable.

A phase tracker holds three named states:
- `PH_IDLE`: no transfer is open.
- `PH_SETUP`: in the previous cycle, select was high and enable was low.
- `PH_WAIT`: in the previous cycle, select and enable were high and ready was low.

Transitions, evaluated on every clock:
- `GO_SETUP`: select=1, enable=0. The next state is `PH_SETUP`.
- `GO_WAIT`: select=1, enable=1, ready=0. The next state is `PH_WAIT`.
- `GO_IDLE`: any other input combination, including completion. The next state is `PH_IDLE`.

A stability checker compares the bus against the previous cycle's values in the states that need it. A capture stage registers the record.

Top module: `apb_xfer_observer`

## Requirements
- R1: A record is produced only for a cycle in which `psel`, `penable` and `pready` are all 1. `rec_valid` is high for exactly one cycle, the cycle after that completion cycle.
- R2: `rec_write` equals `pwrite` in the completion cycle. `rec_data` equals `pwdata` when `pwrite` is 1 and `prdata` when it is 0.
- R3: `rec_addr` and `rec_prot` hold the completion-cycle `paddr` and `pprot`. The bits of `pprot` are: bit 0 = privileged, bit 1 = non-secure, bit 2 = instruction fetch.
- R4: `rec_err` equals `pslverr` in the completion cycle. A high `pslverr` in any earlier cycle of the transfer has no effect on the record.
- R5: A cycle with `psel`=1 and `penable`=1 that follows neither a setup cycle nor a wait cycle sets `viol_order` one clock later.
- R6: A violation during a wait state sets `viol_stable` one clock later. A wait state is a cycle after `psel`=1, `penable`=1, `pready`=0. The violating events are:
  - `psel` falls.
  - `paddr` changes.
  - `pwrite` changes.
  - `pwdata` changes.
- R7: A change of `paddr` or `pwrite` from the setup cycle to the first access cycle sets `viol_stable`. A change of `pwdata` across that boundary does not set it.
- R8: Both violation flags stay set until reset. The asynchronous active-low `rst_n` clears the flags, `rec_valid`, the record fields and the phase state.
- R9: A well-formed transfer sets neither flag. A well-formed transfer has one setup cycle, any number of wait cycles and stable signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| pready | input | 1 | Completer ready |
| pslverr | input | 1 | Completer error response |
| paddr | input | ADDR_W | Transfer address |
| pwdata | input | DATA_W | Write data |
| prdata | input | DATA_W | Read data |
| pprot | input | 3 | Protection attributes |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_write | output | 1 | Recorded direction |
| rec_err | output | 1 | Recorded error status |
| rec_addr | output | ADDR_W | Recorded address |
| rec_data | output | DATA_W | Recorded write or read data |
| rec_prot | output | 3 | Recorded protection attributes |
| viol_order | output | 1 | Sticky ordering violation |
| viol_stable | output | 1 | Sticky stability violation |

## Verification
The assertions check the following on every cycle:
- Each record strobe has a completion handshake behind it.
- The recorded data, address and error match the completion-cycle bus.
- A rise of the ordering flag always follows an access-phase cycle.
- The flags never clear without a reset.

Some behaviour only the bench's scenarios can show. These are the wait-state counts, the choice between write data and read data, and the protection bit positions. They also include the negative cases, which are an error level that is ignored before completion and a write-data change at the setup/access boundary that does not flag. Each violation kind is produced in isolation, followed by the reset that clears it.

// File: rtl/apb_obs_pkg.sv
package apb_obs_pkg;

    // Phase seen on the bus in the previous cycle
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam int PROT_W = 3;

endpackage

// File: rtl/apb_obs_phase.sv
module apb_obs_phase
    import apb_obs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   psel,
    input  logic   penable,
    input  logic   pready,
    output phase_e state,
    output logic   done,
    output logic   order_hit
);

    phase_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state: GO_SETUP, GO_WAIT, GO_IDLE
    always_comb begin
        state_nx = PH_IDLE;
        if (psel && !penable) begin
            state_nx = PH_SETUP;
        end else if (psel && penable && !pready) begin
            state_nx = PH_WAIT;
        end
    end

    // Outputs decoded from the current state and bus
    always_comb begin
        done      = psel && penable && pready;
        order_hit = 1'b0;
        unique case (state)
            PH_IDLE:  order_hit = psel && penable;
            PH_SETUP: order_hit = 1'b0;
            PH_WAIT:  order_hit = 1'b0;
            default:  order_hit = 1'b0;
        endcase
    end

    AST_WAIT_HAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WAIT) |-> $past(psel && penable && !pready)) else $error("wait entry"); // R6

    AST_SETUP_HAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SETUP) |-> $past(psel && !penable)) else $error("setup entry"); // R5

endmodule

// File: rtl/apb_obs_stable.sv
module apb_obs_stable
    import apb_obs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter bit CHK_WDATA = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            state,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic              stable_hit
);

    logic [ADDR_W-1:0] snap_addr;
    logic [DATA_W-1:0] snap_wdata;
    logic              snap_write;
    logic              ctrl_moved;
    logic              data_moved;
    logic              setup_bad;
    logic              wait_bad;

    // Previous-cycle copy of the bus fields under watch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_addr  <= '0;
            snap_wdata <= '0;
            snap_write <= 1'b0;
        end else begin
            snap_addr  <= paddr;
            snap_wdata <= pwdata;
            snap_write <= pwrite;
        end
    end

    assign ctrl_moved = (paddr != snap_addr) || (pwrite != snap_write);

    generate
        if (CHK_WDATA) begin : g_wdata_chk
            assign data_moved = (pwdata != snap_wdata);
        end else begin : g_wdata_skip
            assign data_moved = 1'b0;
        end
    endgenerate

    always_comb begin
        setup_bad = 1'b0;
        wait_bad  = 1'b0;
        unique case (state)
            PH_IDLE: begin
                setup_bad = 1'b0;
            end
            PH_SETUP: begin
                setup_bad = psel && penable && ctrl_moved;
            end
            PH_WAIT: begin
                wait_bad = !psel || (penable && (ctrl_moved || data_moved));
            end
            default: begin
                wait_bad = 1'b0;
            end
        endcase
        stable_hit = setup_bad || wait_bad;
    end

endmodule

// File: rtl/apb_obs_capture.sv
module apb_obs_capture #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PROT_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              pwrite,
    input  logic              pslverr,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic [PROT_W-1:0] pprot,
    output logic              rec_valid,
    output logic              rec_write,
    output logic              rec_err,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [PROT_W-1:0] rec_prot
);

    logic [DATA_W-1:0] data_sel;

    assign data_sel = pwrite ? pwdata : prdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_write <= 1'b0;
            rec_err   <= 1'b0;
            rec_addr  <= '0;
            rec_data  <= '0;
            rec_prot  <= '0;
        end else begin
            rec_valid <= done;
            if (done) begin
                rec_write <= pwrite;
                rec_err   <= pslverr;
                rec_addr  <= paddr;
                rec_data  <= data_sel;
                rec_prot  <= pprot;
            end
        end
    end

endmodule

// File: rtl/apb_xfer_observer.sv
module apb_xfer_observer
    import apb_obs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter bit CHK_WDATA = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic              pready,
    input  logic              pslverr,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic [2:0]        pprot,
    output logic              rec_valid,
    output logic              rec_write,
    output logic              rec_err,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [2:0]        rec_prot,
    output logic              viol_order,
    output logic              viol_stable
);

    phase_e state;
    logic   done;
    logic   order_hit;
    logic   stable_hit;

    apb_obs_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pready    (pready),
        .state     (state),
        .done      (done),
        .order_hit (order_hit)
    );

    apb_obs_stable #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CHK_WDATA (CHK_WDATA)
    ) u_stable (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .stable_hit (stable_hit)
    );

    apb_obs_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PROT_W (PROT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .pwrite    (pwrite),
        .pslverr   (pslverr),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pprot     (pprot),
        .rec_valid (rec_valid),
        .rec_write (rec_write),
        .rec_err   (rec_err),
        .rec_addr  (rec_addr),
        .rec_data  (rec_data),
        .rec_prot  (rec_prot)
    );

    // Sticky violation flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_order  <= 1'b0;
            viol_stable <= 1'b0;
        end else begin
            viol_order  <= viol_order  || order_hit;
            viol_stable <= viol_stable || stable_hit;
        end
    end

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(psel && penable && pready)) else $error("strobe w/o handshake"); // R1

    AST_WDATA_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_write) |-> (rec_data == $past(pwdata))) else $error("write data"); // R2

    AST_RDATA_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_write) |-> (rec_data == $past(prdata))) else $error("read data"); // R2

    AST_ADDR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_addr == $past(paddr) && rec_prot == $past(pprot))) else $error("addr"); // R3

    AST_ERR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_err == $past(pslverr))) else $error("err"); // R4

    AST_ORDER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_order) |-> $past(psel && penable)) else $error("order cause"); // R5

    AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol_order |=> viol_order) else $error("order sticky"); // R8

    AST_STABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol_stable |=> viol_stable) else $error("stable sticky"); // R8

endmodule

// File: tb/apb_xfer_observer_test.sv
module apb_xfer_observer_test;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [2:0]  prot;
        logic        err;
        logic [3:0]  waits;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 32'h0000_0010, 32'hCAFE_0001, 32'h1111_1111, 3'b000, 1'b0, 4'd0},
        '{1'b0, 32'h0000_0014, 32'h2222_2222, 32'hBEEF_0002, 3'b001, 1'b0, 4'd0},
        '{1'b1, 32'h0000_0100, 32'h0BAD_F00D, 32'h3333_3333, 3'b010, 1'b1, 4'd2},
        '{1'b0, 32'hFFFF_FFFC, 32'h4444_4444, 32'h5A5A_A5A5, 3'b100, 1'b1, 4'd3},
        '{1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 3'b111, 1'b0, 4'd1},
        '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 3'b101, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pready = 1'b0, pslverr = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0, prdata = '0;
    logic [2:0]  pprot = '0;
    logic        rec_valid, rec_write, rec_err, viol_order, viol_stable;
    logic [31:0] rec_addr, rec_data;
    logic [2:0]  rec_prot;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    apb_xfer_observer uut (
        .clk (clk), .rst_n (rst_n),
        .psel (psel), .penable (penable), .pwrite (pwrite), .pready (pready),
        .pslverr (pslverr), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .pprot (pprot),
        .rec_valid (rec_valid), .rec_write (rec_write), .rec_err (rec_err),
        .rec_addr (rec_addr), .rec_data (rec_data), .rec_prot (rec_prot),
        .viol_order (viol_order), .viol_stable (viol_stable)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_idle();
        psel = 1'b0; penable = 1'b0; pready = 1'b0; pslverr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_idle();
        #1;
        check("R8 flags clear on reset", {viol_order, viol_stable, rec_valid}, 3'b000);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 clean, 1 wdata moves at access, 2 addr moves in wait,
    //       3 pwrite moves at access, 4 pslverr high during waits
    task automatic xfer(input vec_t v, input int mode);
        logic [31:0] exp_data;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pready = 1'b0; pslverr = 1'b0;
        pwrite = v.wr; paddr = v.addr; pwdata = v.wd; prdata = v.rd; pprot = v.prot;
        @(negedge clk);
        penable = 1'b1;
        if (mode == 1) pwdata = ~v.wd;
        if (mode == 3) pwrite = ~v.wr;
        pready = (v.waits == 0);
        pslverr = (mode == 4 && v.waits != 0) ? 1'b1 : ((v.waits == 0) ? v.err : 1'b0);
        for (int i = 0; i < int'(v.waits); i++) begin
            @(negedge clk);
            check("R1 no record while waiting", {63'd0, rec_valid}, 64'd0);
            if (mode == 2 && i == 0) paddr = v.addr + 32'd4;
            if (i == int'(v.waits) - 1) begin
                pready = 1'b1;
                pslverr = v.err;
            end
        end
        @(negedge clk);
        exp_data = v.wr ? ((mode == 1) ? ~v.wd : v.wd) : v.rd;
        check("R1 record strobe", {63'd0, rec_valid}, 64'd1);
        if (mode != 3 && mode != 2) begin
            check("R2 direction", {63'd0, rec_write}, {63'd0, v.wr});
            check("R2 data", {32'd0, rec_data}, {32'd0, exp_data});
            check("R3 address", {32'd0, rec_addr}, {32'd0, v.addr});
            check("R3 protection bits", {61'd0, rec_prot}, {61'd0, v.prot});
            check("R4 error at completion", {63'd0, rec_err}, {63'd0, v.err});
        end
        bus_idle();
        @(negedge clk);
        check("R1 strobe is one cycle", {63'd0, rec_valid}, 64'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        vec_t v;
        #1;
        check("R8 reset state", {61'd0, rec_valid, viol_order, viol_stable}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: clean transfers, various waits
        for (int k = 0; k < NVEC; k++) begin
            xfer(VEC[k], 0);
        end
        check("R9 clean transfers leave flags low", {62'd0, viol_order, viol_stable}, 64'd0);

        // R7: write data moving at the setup/access boundary is not flagged
        xfer(VEC[0], 1);
        check("R7 wdata change at access ignored", {63'd0, viol_stable}, 64'd0);

        // R4: error level before completion has no effect
        v = VEC[5]; v.err = 1'b0;
        xfer(v, 4);
        check("R4 early error ignored flags", {62'd0, viol_order, viol_stable}, 64'd0);

        // R5: access phase without setup
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pready = 1'b1; pwrite = 1'b1; paddr = 32'h44; pwdata = 32'h55;
        @(negedge clk);
        check("R5 ordering flag", {63'd0, viol_order}, 64'd1);
        check("R5 stability flag untouched", {63'd0, viol_stable}, 64'd0);
        check("R1 handshake still recorded", {63'd0, rec_valid}, 64'd1);
        bus_idle();
        repeat (3) @(negedge clk);
        check("R8 ordering flag sticky", {63'd0, viol_order}, 64'd1);
        do_reset();

        // R6: address moves during a wait state
        xfer(VEC[3], 2);
        check("R6 address change in wait", {63'd0, viol_stable}, 64'd1);
        check("R6 ordering flag untouched", {63'd0, viol_order}, 64'd0);
        do_reset();

        // R7: direction changes from setup to access
        xfer(VEC[0], 3);
        check("R7 pwrite change at access", {63'd0, viol_stable}, 64'd1);
        do_reset();

        // R6: select dropped during a wait state
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 32'h80;
        @(negedge clk);
        penable = 1'b1; pready = 1'b0;
        @(negedge clk);
        bus_idle();
        @(negedge clk);
        check("R6 select dropped in wait", {63'd0, viol_stable}, 64'd1);
        check("R1 no record after abandon", {63'd0, rec_valid}, 64'd0);
        do_reset();
        check("R8 reset clears record strobe", {63'd0, rec_valid}, 64'd0);

        finish_up();
    end

endmodule